// File: doc/BRIEF.md
# Key-Cleared Watchdog Timer

This block is a watchdog counter driven by the system clock. Software must restart it at regular intervals by writing a fixed key byte to a clear register. If software stops doing so, the counter reaches its terminal count and the block raises a one-cycle system reset request. A second register holds a 2-bit selector that picks one of four timeout lengths. A newly written selector value is held back and only becomes the active timeout at the next key-qualified clear. This way, a stray selector write cannot shorten the running interval.

The block also takes two power-state levels from the clock controller. While the system idles, the counter keeps running, and a software disable request is honoured only in this state. While the system is powered down, the counter freezes, because no clock edges reach the logic it models. A resume-from-power-down event puts all watchdog state back to its reset values.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `wdt_reset` is 0, the watchdog is enabled and counting, and the prescaler register (address 1) reads 0x00.
- R2: A write of 0x55 to the clear register (address 0) sets the counter to zero on that clock edge, so the next reset pulse moves out to a full timeout later.
- R3: A write of any byte other than 0x55 to address 0 leaves the counter untouched. So does a write of 0x55 to address 1.
- R4: Let the active selector be s. The reset pulse is asserted on the clock edge that is 2^(BASE_EXP+s) edges after the edge that zeroed the counter. This holds for s = 00, 01, 10 and 11.
- R5: A write to address 1 stores bits [1:0] at once. Reads of address 1 return the new value, but the active timeout changes only at the next 0x55 clear.
- R6: `wdt_reset` is high for exactly one cycle. The counter restarts from zero on that same edge, so pulses repeat every timeout while nothing clears the counter.
- R7: A high `sw_disable` sampled while `idle_mode` is 1 turns the watchdog off, after which no reset pulse occurs. A request sampled while `idle_mode` is 0 is ignored.
- R8: While `pdown_mode` is 1, the counter holds its value and no pulse is produced. Each powered-down cycle delays the pulse by one cycle.
- R9: A one-cycle `resume_evt` zeroes the counter, re-enables the watchdog, and returns both the pending and the active selector to 00.
- R10: Reads have one cycle of latency on `bus_rdata`. Address 0 reads 0x00, and bits [7:2] of address 1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | Register address: 0 clear, 1 prescaler |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| idle_mode | input | 1 | System is in idle state |
| pdown_mode | input | 1 | System is powered down; counting frozen |
| resume_evt | input | 1 | Pulse on wake from power-down |
| sw_disable | input | 1 | Software request to stop the watchdog |
| wdt_reset | output | 1 | One-cycle system reset request |

## Verification
A wrong internal state shows up on one pin: the time at which `wdt_reset` rises. A miscounted counter, a selector loaded too early, a missed freeze, or an accepted non-key write each move that pulse by at least one cycle, within one timeout (at most 2^(BASE_EXP+3) cycles). The bench predicts each pulse edge from the last zeroing event and flags early, late, missing and extra pulses. A lost disable shows up as a pulse inside a window where none may occur. The pending selector is visible through a read one cycle after the request.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 1;
  localparam logic [DATA_W-1:0] KEY_BYTE = 8'h55;
  localparam logic [ADDR_W-1:0] ADDR_CLR = 1'b0;
  localparam logic [ADDR_W-1:0] ADDR_SEL = 1'b1;

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } bus_cmd_t;
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import keyed_wdt_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              resume_i,
  input  bus_cmd_t          cmd_i,
  output logic              key_hit_o,
  output logic [SEL_W-1:0]  act_sel_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [SEL_W-1:0]  pend_sel_q;
  logic [SEL_W-1:0]  act_sel_q;
  logic [DATA_W-1:0] rdata_q;
  logic              sel_wr;

  assign key_hit_o = cmd_i.wr && (cmd_i.addr == ADDR_CLR) && (cmd_i.data == KEY_BYTE);
  assign sel_wr    = cmd_i.wr && (cmd_i.addr == ADDR_SEL);

  always_ff @(posedge clk) begin
    if (rst || resume_i) begin
      pend_sel_q <= '0;
      act_sel_q  <= '0;
      rdata_q    <= '0;
    end else begin
      if (sel_wr)
        pend_sel_q <= cmd_i.data[SEL_W-1:0];
      if (key_hit_o)
        act_sel_q <= pend_sel_q;
      if (cmd_i.rd) begin
        if (cmd_i.addr == ADDR_SEL)
          rdata_q <= {{(DATA_W-SEL_W){1'b0}}, pend_sel_q};
        else
          rdata_q <= '0;
      end
    end
  end

  assign act_sel_o = act_sel_q;
  assign rdata_o   = rdata_q;

  p_sel_defer_r5: assert property (@(posedge clk) disable iff (rst)
    (!key_hit_o && !resume_i) |=> $stable(act_sel_q));

  p_sel_load_r5: assert property (@(posedge clk) disable iff (rst)
    (key_hit_o && !resume_i) |=> (act_sel_q == $past(pend_sel_q)));

  p_clr_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_i.rd && cmd_i.addr == ADDR_CLR && !resume_i) |=> (rdata_q == '0));

  p_resv_zero_r10: assert property (@(posedge clk) disable iff (rst)
    rdata_q[DATA_W-1:SEL_W] == '0);
endmodule

// File: rtl/kwdt_enable.sv
module kwdt_enable (
  input  logic clk,
  input  logic rst,
  input  logic resume_i,
  input  logic idle_i,
  input  logic dis_req_i,
  output logic en_o
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst || resume_i)
      en_q <= 1'b1;
    else if (dis_req_i && idle_i)
      en_q <= 1'b0;
  end

  assign en_o = en_q;

  p_dis_idle_only_r7: assert property (@(posedge clk) disable iff (rst)
    (en_q && !idle_i) |=> en_q);

  p_on_after_resume_r9: assert property (@(posedge clk) disable iff (rst)
    resume_i |=> en_q);
endmodule

// File: rtl/kwdt_limit.sv
module kwdt_limit #(
  parameter int SEL_W    = 2,
  parameter int BASE_EXP = 16,
  parameter int CNT_W    = BASE_EXP + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] term_o
);
  localparam int NSEL = 1 << SEL_W;

  logic [CNT_W-1:0] term_tab [NSEL];
  logic [CNT_W-1:0] term_q;

  for (genvar i = 0; i < NSEL; i++) begin : g_term
    localparam logic [CNT_W:0] ONE_HOT = (CNT_W+1)'(1) << (BASE_EXP + i);
    localparam logic [CNT_W:0] TERM_W  = ONE_HOT - (CNT_W+1)'(1);
    assign term_tab[i] = TERM_W[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      term_q <= term_tab[0];
    else
      term_q <= term_tab[sel_i];
  end

  assign term_o = term_q;
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic             en_i,
  input  logic             freeze_i,
  input  logic [CNT_W-1:0] term_i,
  output logic             pulse_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pulse_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (freeze_i) begin
      pulse_q <= 1'b0;
    end else if (cnt_q == term_i) begin
      cnt_q   <= '0;
      pulse_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      pulse_q <= 1'b0;
    end
  end

  assign pulse_o = pulse_q;

  p_restart_zero_r2: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (cnt_q == '0 && !pulse_q));

  p_freeze_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (freeze_i && en_i && !restart_i) |=> (cnt_q == $past(cnt_q) && !pulse_q));

  p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);

  p_pulse_restart_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_q) |-> (cnt_q == '0));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import keyed_wdt_pkg::*;
#(
  parameter int BASE_EXP = 16,
  parameter int SEL_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              idle_mode,
  input  logic              pdown_mode,
  input  logic              resume_evt,
  input  logic              sw_disable,
  output logic              wdt_reset
);
  localparam int CNT_W = BASE_EXP + (1 << SEL_W) - 1;

  bus_cmd_t         cmd;
  logic             key_hit;
  logic [SEL_W-1:0] act_sel;
  logic             wdt_en;
  logic [CNT_W-1:0] term;
  logic             restart;

  assign cmd.wr   = bus_wr;
  assign cmd.rd   = bus_rd;
  assign cmd.addr = bus_addr;
  assign cmd.data = bus_wdata;

  assign restart = key_hit || resume_evt;

  kwdt_regs #(.SEL_W(SEL_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .resume_i  (resume_evt),
    .cmd_i     (cmd),
    .key_hit_o (key_hit),
    .act_sel_o (act_sel),
    .rdata_o   (bus_rdata)
  );

  kwdt_enable u_enable (
    .clk       (clk),
    .rst       (rst),
    .resume_i  (resume_evt),
    .idle_i    (idle_mode),
    .dis_req_i (sw_disable),
    .en_o      (wdt_en)
  );

  kwdt_limit #(.SEL_W(SEL_W), .BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_limit (
    .clk    (clk),
    .rst    (rst),
    .sel_i  (act_sel),
    .term_o (term)
  );

  kwdt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst       (rst),
    .restart_i (restart),
    .en_i      (wdt_en),
    .freeze_i  (pdown_mode),
    .term_i    (term),
    .pulse_o   (wdt_reset)
  );

  p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (rst)
    (!wdt_en && !resume_evt) |=> !wdt_reset);

  p_no_pulse_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    pdown_mode |=> !wdt_reset);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !wdt_reset);
endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
  localparam int BEXP = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [0:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       idle_mode = 1'b0, pdown_mode = 1'b0, resume_evt = 1'b0, sw_disable = 1'b0;
  logic       wdt_reset;

  always #5 clk = ~clk;

  keyed_watchdog #(.BASE_EXP(BEXP), .SEL_W(2)) i_keyed_watchdog (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .idle_mode(idle_mode),
    .pdown_mode(pdown_mode), .resume_evt(resume_evt), .sw_disable(sw_disable),
    .wdt_reset(wdt_reset)
  );

  int    cyc = 0;
  int    n_vec = 0, n_bad = 0, pulses = 0;
  int    exp_q[$];
  string tag_q[$];
  string quiet_tag = "R2";
  bit    prev_p = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops the scoreboard whenever a pulse appears or is overdue
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      if (wdt_reset) begin
        pulses++;
        if (prev_p) begin
          n_vec++; n_bad++;
          $display("FAIL R6: pulse still high at cycle %0d, got 1 expected 0", cyc);
        end
        if (exp_q.size() == 0) begin
          n_vec++; n_bad++;
          $display("FAIL %s: unexpected pulse at cycle %0d, got 1 expected 0", quiet_tag, cyc);
        end else begin
          int    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          n_vec++;
          if (cyc != e) begin
            n_bad++;
            $display("FAIL %s: pulse at cycle %0d, expected %0d", t, cyc, e);
          end
        end
      end else if (exp_q.size() > 0 && cyc > exp_q[0]) begin
        n_vec++; n_bad++;
        $display("FAIL %s: pulse missing, got none by %0d expected %0d", tag_q[0], cyc, exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
    prev_p = wdt_reset;
  end

  task automatic expect_at(input int c, input string t);
    exp_q.push_back(c);
    tag_q.push_back(t);
  endtask

  task automatic flush_exp();
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d, output int t);
    @(negedge clk);
    t = cyc;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic key_clear(output int t);
    bus_write(1'b0, 8'h55, t);
    flush_exp();
  endtask

  task automatic read_chk(input logic a, input logic [7:0] e, input string tg);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    n_vec++;
    if (bus_rdata !== e) begin
      n_bad++;
      $display("FAIL %s: read addr %0d got %02h expected %02h", tg, a, bus_rdata, e);
    end
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
    finish_run();
  end

  initial begin
    int r, t, p0;
    // R1: reset state
    repeat (3) @(negedge clk);
    r = cyc;
    rst = 1'b0;
    n_vec++;
    if (wdt_reset !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: wdt_reset got %0b expected 0", wdt_reset);
    end
    expect_at(r + 16, "R1 R4");
    expect_at(r + 32, "R6");
    read_chk(1'b1, 8'h00, "R1");
    read_chk(1'b0, 8'h00, "R10");
    drain();

    // R2 / R3 / R5: key restart, ignored writes, deferred selector
    key_clear(t);
    expect_at(t + 17, "R2 R3");
    expect_at(t + 33, "R5");
    begin
      int dummy;
      bus_write(1'b0, 8'h54, dummy);
      bus_write(1'b0, 8'hAA, dummy);
      bus_write(1'b0, 8'h00, dummy);
      bus_write(1'b1, 8'h55, dummy);
    end
    read_chk(1'b1, 8'h01, "R5");
    read_chk(1'b0, 8'h00, "R10");
    drain();

    // R4: each selector length
    key_clear(t);
    expect_at(t + 1 + 32, "R4 sel01");
    bus_write(1'b1, 8'hFF, p0);
    read_chk(1'b1, 8'h03, "R10");
    drain();
    key_clear(t);
    expect_at(t + 1 + 128, "R4 sel11");
    bus_write(1'b1, 8'h02, p0);
    drain();
    key_clear(t);
    expect_at(t + 1 + 64, "R4 sel10");
    drain();

    // R7: disable ignored outside idle, honoured in idle
    key_clear(t);
    expect_at(t + 1 + 64, "R7");
    @(negedge clk); sw_disable = 1'b1;
    @(negedge clk); sw_disable = 1'b0;
    drain();
    key_clear(t);
    quiet_tag = "R7";
    @(negedge clk); idle_mode = 1'b1; sw_disable = 1'b1;
    @(negedge clk); idle_mode = 1'b0; sw_disable = 1'b0;
    p0 = pulses;
    repeat (150) @(negedge clk);
    n_vec++;
    if (pulses != p0) begin
      n_bad++;
      $display("FAIL R7: pulses while disabled got %0d expected 0", pulses - p0);
    end

    // R9: resume restores defaults
    @(negedge clk);
    t = cyc;
    resume_evt = 1'b1;
    @(negedge clk);
    resume_evt = 1'b0;
    quiet_tag = "R9";
    expect_at(t + 17, "R9");
    read_chk(1'b1, 8'h00, "R9");
    drain();

    // R8: power-down freeze delays the pulse
    key_clear(t);
    quiet_tag = "R8";
    expect_at(t + 17 + 7, "R8");
    repeat (4) @(negedge clk);
    pdown_mode = 1'b1;
    repeat (7) @(negedge clk);
    pdown_mode = 1'b0;
    drain();
    finish_run();
  end
endmodule